// File: doc/BRIEF.md
# Write Protection and Status Register Unit

This unit is the protection core of a serial byte-wide nonvolatile memory. It keeps the write-enable latch and three persistent protection bits: a pin-lock enable and a two-bit block-protect level. It combines them with the external write-protect pin to answer two questions every cycle. The first is whether the array byte at the queried address may be programmed. The second is whether the status register itself may be rewritten. It also builds the 8-bit status byte that the serial front end shifts out on a status-read command. The array storage, the serial shifter and the timed programming engine sit outside.

The serial front end delivers decoded commands as single-cycle strobes: set-enable, clear-enable and status-write, the last with its data byte. It also drives a level that is high while the chip select is asserted. The programming engine drives a busy level and a one-cycle completion pulse. A status write that is accepted is held pending until chip select is released. It is committed to the persistent bits on the completion pulse of the timed cycle that follows. Every port is a plain control or status pin. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

The persistent bits take the value of parameter `NV_INIT` only on the power-up reset `por_n`. The ordinary reset `rst_n` clears only the volatile state.

Top module: `wp_status_unit`

## Requirements
- R1: After `por_n` is asserted the persistent bits equal `NV_INIT` (default all zero), write-enable is 0, and the idle status byte reads 0x00.
- R2: When not busy, the status byte is {lock-enable at bit 7, zeros at bits 6:4, protect level high bit at bit 3, low bit at bit 2, write-enable at bit 1, 0 at bit 0}.
- R3: While `busy` is high the status byte reads 0xFF.
- R4: A set-enable strobe sets write-enable only if `wp_pin` is high. A clear-enable strobe clears it whatever the level of `wp_pin`.
- R5: While `busy` is high, set-enable, clear-enable and status-write strobes have no effect.
- R6: The protect level selects the protected quarters, taken from the two top address bits: level 0 protects none, level 1 protects quarter 3, level 2 protects quarters 2 and 3, and level 3 protects all quarters. `array_wr_ok` is write-enable AND NOT protected(`query_addr`).
- R7: The hardware lock is lock-enable AND `wp_pin` low. `status_wr_ok` is write-enable AND NOT lock. A status-write strobe is accepted only while `status_wr_ok` is high. When lock-enable is 0, `wp_pin` does not affect `status_wr_ok`.
- R8: An accepted status write is cancelled if the lock becomes active while `sel_active` is still high. Once `sel_active` has fallen, `wp_pin` no longer affects it.
- R9: The pending status bits (data bits 7, 3 and 2) are committed on `write_done`, and `write_done` clears write-enable.
- R10: `rst_n` alone clears write-enable and any pending status write but keeps the persistent bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, clears all state and loads NV_INIT |
| rst_n | input | 1 | Ordinary reset, active low, clears volatile state only |
| cmd_wren | input | 1 | Set-enable command strobe |
| cmd_wrdi | input | 1 | Clear-enable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| wrsr_data | input | 8 | Status-write data byte |
| sel_active | input | 1 | High while chip select is asserted |
| wp_pin | input | 1 | Write-protect pin, high allows writes |
| busy | input | 1 | Timed write cycle in progress |
| write_done | input | 1 | One-cycle pulse at the end of a write cycle |
| query_addr | input | ADDR_W | Array address whose writability is queried |
| status_byte | output | 8 | Status byte for status reads |
| array_wr_ok | output | 1 | Queried array address may be written |
| status_wr_ok | output | 1 | Status register may be written |

## Verification
The protection decode is probed at addresses just below and just above each quarter boundary for every protect level. This separates an off-by-one quarter from a correct decode. Status writes are driven in three patterns: undisturbed, with the pin dropped while chip select is held, and with the pin dropped only during the busy phase. Only the second pattern must leave the old bits in place. The pin is also held low with the lock enable clear and with it set. This separates "pin ignored" from "pin locks". The two resets are applied on their own, which tells the volatile state apart from the persistent state.

// File: rtl/wpsr_pkg.sv
package wpsr_pkg;
  typedef struct packed {
    logic lock_en;
    logic lvl_hi;
    logic lvl_lo;
  } nv_bits_t;

  localparam int unsigned STATUS_W = 8;
  localparam int unsigned QUARTERS = 4;
endpackage

// File: rtl/wpsr_wen_latch.sv
module wpsr_wen_latch (
  input  logic clk,
  input  logic vrst_n,
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic wp_pin,
  input  logic busy,
  input  logic write_done,
  output logic wen_q
);
  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n) begin
      wen_q <= 1'b0;
    end else if (write_done) begin
      wen_q <= 1'b0;
    end else if (!busy) begin
      if (cmd_wrdi) wen_q <= 1'b0;
      else if (cmd_wren && wp_pin) wen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wpsr_nv_store.sv
module wpsr_nv_store
  import wpsr_pkg::*;
#(
  parameter nv_bits_t NV_INIT = '0
) (
  input  logic     clk,
  input  logic     por_n,
  input  logic     vrst_n,
  input  logic     accept,
  input  nv_bits_t new_bits,
  input  logic     sel_active,
  input  logic     hw_lock,
  input  logic     write_done,
  output nv_bits_t nv_q
);
  nv_bits_t pend_q;
  logic     pend_v;
  logic     launched;

  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n) begin
      pend_v   <= 1'b0;
      launched <= 1'b0;
      pend_q   <= '0;
    end else if (write_done) begin
      pend_v   <= 1'b0;
      launched <= 1'b0;
    end else if (accept) begin
      pend_v   <= 1'b1;
      launched <= 1'b0;
      pend_q   <= new_bits;
    end else if (pend_v && !launched) begin
      if (sel_active && hw_lock) pend_v <= 1'b0;
      else if (!sel_active) launched <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) nv_q <= NV_INIT;
    else if (write_done && pend_v && launched) nv_q <= pend_q;
  end
endmodule

// File: rtl/wpsr_prot_decode.sv
module wpsr_prot_decode
  import wpsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned QSEL_LSB = ADDR_W - 2;

  logic [QUARTERS-1:0] qmask;
  logic [1:0]          quarter;
  logic                unused_low;

  assign quarter    = addr[ADDR_W-1:QSEL_LSB];
  assign unused_low = ^addr[QSEL_LSB-1:0];

  for (genvar g = 0; g < QUARTERS; g++) begin : g_quarter
    localparam logic [1:0] NEED = (g == 3) ? 2'd1 : (g == 2) ? 2'd2 : 2'd3;
    assign qmask[g] = (level >= NEED);
  end

  assign hit = qmask[quarter];
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wpsr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter nv_bits_t    NV_INIT = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              sel_active,
  input  logic              wp_pin,
  input  logic              busy,
  input  logic              write_done,
  input  logic [ADDR_W-1:0] query_addr,
  output logic [7:0]        status_byte,
  output logic              array_wr_ok,
  output logic              status_wr_ok
);
  logic     vrst_n;
  logic     wen_q;
  logic     hw_lock;
  logic     prot_hit;
  logic     accept;
  nv_bits_t nv_q;
  nv_bits_t new_bits;
  logic     unused_data;

  assign vrst_n      = por_n & rst_n;
  assign hw_lock     = nv_q.lock_en & ~wp_pin;
  assign new_bits    = '{lock_en: wrsr_data[7], lvl_hi: wrsr_data[3], lvl_lo: wrsr_data[2]};
  assign unused_data = ^{wrsr_data[6:4], wrsr_data[1:0]};

  wpsr_wen_latch u_wen (
    .clk        (clk),
    .vrst_n     (vrst_n),
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .wp_pin     (wp_pin),
    .busy       (busy),
    .write_done (write_done),
    .wen_q      (wen_q)
  );

  assign status_wr_ok = wen_q & ~hw_lock;
  assign accept       = cmd_wrsr & status_wr_ok & ~busy;

  wpsr_nv_store #(.NV_INIT(NV_INIT)) u_nv (
    .clk        (clk),
    .por_n      (por_n),
    .vrst_n     (vrst_n),
    .accept     (accept),
    .new_bits   (new_bits),
    .sel_active (sel_active),
    .hw_lock    (hw_lock),
    .write_done (write_done),
    .nv_q       (nv_q)
  );

  wpsr_prot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .level (nv_q[1:0]),
    .addr  (query_addr),
    .hit   (prot_hit)
  );

  assign array_wr_ok = wen_q & ~prot_hit;

  always_comb begin
    if (busy) status_byte = 8'hFF;
    else status_byte = {nv_q.lock_en, 3'b000, nv_q.lvl_hi, nv_q.lvl_lo, wen_q, 1'b0};
  end
endmodule

// File: rtl/wpsr_checker.sv
module wpsr_checker (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       busy,
  input logic       write_done,
  input logic       wp_pin,
  input logic       wen_q,
  input logic [2:0] nv_q,
  input logic [7:0] status_byte,
  input logic       array_wr_ok,
  input logic       status_wr_ok
);
  AST_BUSY_ALL_ONES: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    busy |-> status_byte == 8'hFF); // R3
  AST_WREN_NEEDS_PIN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(wen_q) |-> $past(wp_pin)); // R4
  AST_BUSY_KEEPS_WEN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (busy && !write_done) |=> $stable(wen_q)); // R5
  AST_FULL_LEVEL_BLOCKS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (nv_q[1:0] == 2'b11) |-> !array_wr_ok); // R6
  AST_LOCK_BLOCKS_STATUS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (nv_q[2] && !wp_pin) |-> !status_wr_ok); // R7
  AST_DONE_CLEARS_WEN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    write_done |=> !wen_q); // R9
  AST_NV_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!por_n)
    !write_done |=> $stable(nv_q)); // R9
  AST_NO_WEN_NO_WRITE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !wen_q |-> (!array_wr_ok && !status_wr_ok)); // R6
endmodule

bind wp_status_unit wpsr_checker u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .rst_n        (rst_n),
  .busy         (busy),
  .write_done   (write_done),
  .wp_pin       (wp_pin),
  .wen_q        (wen_q),
  .nv_q         (nv_q),
  .status_byte  (status_byte),
  .array_wr_ok  (array_wr_ok),
  .status_wr_ok (status_wr_ok)
);

// File: tb/tb_wp_status_unit.sv
module tb_wp_status_unit;
  localparam int TCLK   = 10;
  localparam int ADDR_W = 15;

  typedef struct {
    string      req;
    logic [7:0] st;
    logic       arr;
    logic       sok;
  } exp_t;

  logic clk = 1'b0;
  logic por_n, rst_n, cmd_wren, cmd_wrdi, cmd_wrsr, sel_active, wp_pin, busy, write_done;
  logic [7:0] wrsr_data;
  logic [ADDR_W-1:0] query_addr;
  logic [7:0] status_byte;
  logic array_wr_ok, status_wr_ok;

  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;
  exp_t sbq[$];

  always #(TCLK/2) clk = ~clk;

  wp_status_unit #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .sel_active(sel_active), .wp_pin(wp_pin),
    .busy(busy), .write_done(write_done), .query_addr(query_addr),
    .status_byte(status_byte), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok)
  );

  // Monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (status_byte !== e.st || array_wr_ok !== e.arr || status_wr_ok !== e.sok) begin
          errors++;
          $display("FAIL %s: got st=%02h arr=%b sok=%b expected st=%02h arr=%b sok=%b",
                   e.req, status_byte, array_wr_ok, status_wr_ok, e.st, e.arr, e.sok);
        end
      end
    end
  end

  task automatic expect_out(input string req, input logic [ADDR_W-1:0] a,
                            input logic [7:0] st, input logic arr, input logic sok);
    exp_t e;
    query_addr = a;
    e.req = req; e.st = st; e.arr = arr; e.sok = sok;
    sbq.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe_wren();
    cmd_wren = 1'b1; tick(); cmd_wren = 1'b0;
  endtask

  task automatic strobe_wrdi();
    cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
  endtask

  task automatic wrsr_begin(input logic [7:0] d);
    sel_active = 1'b1; wrsr_data = d; cmd_wrsr = 1'b1; tick(); cmd_wrsr = 1'b0; tick();
  endtask

  task automatic finish_cycle();
    sel_active = 1'b0; tick();
    busy = 1'b1; tick(); tick();
    write_done = 1'b1; tick();
    write_done = 1'b0; busy = 1'b0; tick();
  endtask

  initial begin
    por_n = 0; rst_n = 0; cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; wrsr_data = 0;
    sel_active = 0; wp_pin = 1; busy = 0; write_done = 0; query_addr = 0;
    repeat (3) tick();
    por_n = 1; rst_n = 1; tick();
    expect_out("R1 reset state", 15'h0000, 8'h00, 1'b0, 1'b0);

    wp_pin = 0; strobe_wren(); tick();
    expect_out("R4 set-enable with pin low", 15'h0000, 8'h00, 1'b0, 1'b0);
    wp_pin = 1; strobe_wren(); tick();
    expect_out("R2 write-enable bit", 15'h7FFF, 8'h02, 1'b1, 1'b1);
    wp_pin = 0; strobe_wrdi(); tick();
    expect_out("R4 clear-enable with pin low", 15'h0000, 8'h00, 1'b0, 1'b0);

    wp_pin = 1; strobe_wren(); wrsr_begin(8'hF4);
    sel_active = 1'b0; tick(); busy = 1'b1; tick();
    expect_out("R3 busy reads all ones", 15'h0000, 8'hFF, 1'b1, 1'b1);
    tick(); write_done = 1'b1; tick(); write_done = 1'b0; busy = 1'b0; tick();
    expect_out("R9 commit lock+level1, unused bits zero", 15'h0000, 8'h84, 1'b0, 1'b0);

    strobe_wren(); tick();
    expect_out("R6 level1 below boundary", 15'h5FFF, 8'h86, 1'b1, 1'b1);
    expect_out("R6 level1 at boundary", 15'h6000, 8'h86, 1'b0, 1'b1);
    wp_pin = 0; tick();
    expect_out("R7 pin low with lock enabled", 15'h1000, 8'h86, 1'b1, 1'b0);

    wrsr_begin(8'h00); finish_cycle();
    expect_out("R7 locked status write refused", 15'h0000, 8'h84, 1'b0, 1'b0);

    wp_pin = 1; strobe_wren(); wrsr_begin(8'h08);
    wp_pin = 0; tick(); wp_pin = 1; tick(); finish_cycle();
    expect_out("R8 cancelled by pin under select", 15'h0000, 8'h84, 1'b0, 1'b0);

    strobe_wren(); wrsr_begin(8'h08);
    sel_active = 1'b0; tick(); busy = 1'b1; wp_pin = 0; tick(); tick();
    write_done = 1'b1; tick(); write_done = 1'b0; busy = 1'b0; wp_pin = 1; tick();
    expect_out("R8 pin during busy has no effect", 15'h0000, 8'h08, 1'b0, 1'b0);

    strobe_wren(); tick();
    expect_out("R6 level2 below boundary", 15'h3FFF, 8'h0A, 1'b1, 1'b1);
    expect_out("R6 level2 at boundary", 15'h4000, 8'h0A, 1'b0, 1'b1);

    busy = 1'b1; strobe_wrdi(); busy = 1'b0; tick();
    expect_out("R5 clear-enable ignored while busy", 15'h0000, 8'h0A, 1'b1, 1'b1);
    busy = 1'b1; cmd_wrsr = 1'b1; wrsr_data = 8'h8C; tick(); cmd_wrsr = 1'b0; busy = 1'b0;
    sel_active = 1'b0; tick(); tick();
    write_done = 1'b1; tick(); write_done = 1'b0; tick();
    expect_out("R5 status write ignored while busy", 15'h0000, 8'h08, 1'b0, 1'b0);

    strobe_wren(); wp_pin = 0; tick();
    expect_out("R7 pin ignored with lock clear", 15'h0000, 8'h0A, 1'b1, 1'b1);
    wrsr_begin(8'h0C); finish_cycle();
    wp_pin = 1; strobe_wren(); tick();
    expect_out("R6 level3 protects all", 15'h0000, 8'h0E, 1'b0, 1'b1);

    rst_n = 0; tick(); rst_n = 1; tick();
    expect_out("R10 ordinary reset keeps level", 15'h0000, 8'h0C, 1'b0, 1'b0);
    por_n = 0; tick(); por_n = 1; tick();
    expect_out("R1 power-up reset clears level", 15'h7FFF, 8'h00, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(TCLK * 100000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule